// File: doc/BRIEF.md
# Multi-channel fragment receive DMA

This block carries data fragments from several independent link receive channels into host memory. Each channel takes 32-bit words from its link stream, with a marker on the last word of a fragment. Before a fragment can land, the host must give the channel a free page address through that channel's request queue. The channel packs word pairs into 64-bit beats, stages them in a local burst buffer, and writes them to the page through one shared burst-write master port. When the fragment is finished, it posts a completion entry to its acknowledge queue.

The channels take the master port in turn, one burst per grant. A fragment longer than one burst goes out as several bursts at rising addresses. A fragment longer than its page is cut at the page end. A level interrupt tells the host that completions are waiting on any channel whose interrupt enable is set.

Top module: `frag_rx_dma`

## Requirements
- R1: Each fragment takes exactly one page address from its channel's request queue, in push order. The first beat of the fragment goes to that page address. Page addresses must be 8-byte aligned. The completion entry carries that page address in bits [ADDR_W+31:32].
- R2: Link words are packed in pairs. The earlier word goes in beat bits [31:0] and the later word in bits [63:32]. Successive beats of a fragment go to successive 8-byte addresses.
- R3: A fragment with an odd word count ends with a beat whose bits [63:32] are zero. Its completion entry has status bit 25 set. The length field (bits [23:0], in bytes) counts 4 bytes per stored word, so no pad bytes are included.
- R4: No burst exceeds BURST_BYTES, which must be at most 1024. A longer fragment is split into full bursts followed by a remainder burst, each starting where the previous one ended. m_last marks the final beat of every burst, and m_addr holds the burst start address for the whole burst.
- R5: While a channel has no page address, lk_ready stays low on that channel. Words offered during that time are held by the source, not lost. They all reach memory once a page arrives.
- R6: Words beyond PAGE_BYTES in one fragment are discarded and never written. The entry then reports length PAGE_BYTES with status bit 24 set.
- R7: When a channel's acknowledge queue is full, that channel holds its finished fragment and accepts no new link words. Once the host pops an entry, the held entry is posted, and the order of entries is kept.
- R8: At most one channel holds the master port at a time. A channel gets the port only while m_valid is driven for that channel. When several channels wait, grants rotate, so back-to-back bursts come from different channels.
- R9: irq is high exactly when some channel has both its irq_en bit set and a non-empty acknowledge queue.
- R10: While m_valid is high and m_ready is low, m_valid, m_addr, m_data and m_last stay unchanged.
- R11: After reset, lk_ready and m_valid are low, every ack_empty bit is high, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_push | input | NUM_CH | Per-channel page address push strobe |
| req_addr | input | NUM_CH*ADDR_W | Per-channel page address to push |
| req_full | output | NUM_CH | Per-channel request queue full |
| ack_pop | input | NUM_CH | Per-channel completion entry pop strobe |
| ack_data | output | NUM_CH*(ADDR_W+32) | Per-channel head completion entry: page address, status, length |
| ack_empty | output | NUM_CH | Per-channel acknowledge queue empty |
| lk_valid | input | NUM_CH | Link word valid |
| lk_data | input | NUM_CH*32 | Link word |
| lk_end | input | NUM_CH | Word is the last of its fragment |
| lk_ready | output | NUM_CH | Channel accepts a link word |
| m_valid | output | 1 | Master beat valid |
| m_ready | input | 1 | Master beat accepted |
| m_addr | output | ADDR_W | Start byte address of the current burst |
| m_data | output | 64 | Master beat data |
| m_last | output | 1 | Final beat of the burst |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| irq | output | 1 | Completion interrupt, level |

## Verification
The hardest case to reach is a channel that has already accepted a whole fragment but cannot post it, because its acknowledge queue is full. The channel must stall its link input while a new page is waiting. The bench fills a two-entry acknowledge queue without popping, sends a third fragment, and then offers a fourth with a page already queued. It checks that lk_ready stays low until one entry is popped, and then that all four entries come out in order. Rotation is forced by slowing m_ready to one beat in three, so that both channels are always waiting when a grant is decided.

// File: rtl/fragdma_pkg.sv
package fragdma_pkg;
   typedef enum logic [2:0] {
      ST_PAGE,
      ST_FILL,
      ST_REQ,
      ST_SEND,
      ST_ACK
   } ch_state_e;

   localparam int STAT_OVF_BIT = 24;
   localparam int STAT_PAD_BIT = 25;
   localparam int LEN_W        = 24;
endpackage

// File: rtl/fragdma_fifo.sv
module fragdma_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] wi, ri;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == (AW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[ri];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wi  <= '0;
         ri  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wi <= (wi == AW'(DEPTH-1)) ? '0 : wi + 1'b1;
         if (do_pop)  ri <= (ri == AW'(DEPTH-1)) ? '0 : ri + 1'b1;
         cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wi] <= din;
   end
endmodule

// File: rtl/fragdma_rr_arb.sv
module fragdma_rr_arb #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          done,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] owner
);
   logic busy;

   generate
      if (N == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)                busy <= 1'b0;
            else if (busy && done)     busy <= 1'b0;
            else if (!busy && req[0])  busy <= 1'b1;
         end
         assign gnt   = busy;
         assign owner = '0;
      end else begin : g_rotate
         logic [IW-1:0] own_q, pick;
         logic          found;

         always_comb begin
            pick  = own_q;
            found = 1'b0;
            for (int k = 1; k <= N; k++) begin
               int idx;
               idx = (int'(own_q) + k) % N;
               if (!found && req[idx]) begin
                  found = 1'b1;
                  pick  = IW'(idx);
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               busy  <= 1'b0;
               own_q <= '0;
            end else if (busy) begin
               if (done) busy <= 1'b0;
            end else if (found) begin
               busy  <= 1'b1;
               own_q <= pick;
            end
         end

         for (genvar i = 0; i < N; i++) begin : g_gnt
            assign gnt[i] = busy && (own_q == IW'(i));
         end
         assign owner = own_q;
      end
   endgenerate
endmodule

// File: rtl/fragdma_chan.sv
module fragdma_chan
   import fragdma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int BURST_BEATS = 128,
   parameter int PAGE_WORDS  = 1024,
   parameter int REQ_DEPTH   = 8,
   parameter int ACK_DEPTH   = 8,
   localparam int ACK_W      = ADDR_W + 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_push,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_full,
   input  logic              ack_pop,
   output logic [ACK_W-1:0]  ack_data,
   output logic              ack_empty,
   input  logic              lk_valid,
   input  logic [31:0]       lk_data,
   input  logic              lk_end,
   output logic              lk_ready,
   output logic              m_req,
   input  logic              m_gnt,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [ADDR_W-1:0] m_addr,
   output logic [63:0]       m_data,
   output logic              m_last
);
   localparam int BW  = $clog2(BURST_BEATS + 1);
   localparam int BIW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
   localparam int WW  = $clog2(PAGE_WORDS + 1);

   ch_state_e         st;
   logic [63:0]       bbuf [BURST_BEATS];
   logic [ADDR_W-1:0] page_base, burst_addr, pg_addr;
   logic [WW-1:0]     wcnt;
   logic [BW-1:0]     beats, beats_nx, rd_idx;
   logic [31:0]       half_lo;
   logic              have_half, ovf, pad, done;
   logic              pg_empty, pg_pop, ack_full, ack_push;
   logic              acc, room, store_beat, is_last;
   logic [ACK_W-1:0]  ack_din;

   fragdma_fifo #(.W(ADDR_W), .DEPTH(REQ_DEPTH)) u_req (
      .clk(clk), .rst_n(rst_n), .push(req_push), .din(req_addr),
      .pop(pg_pop), .dout(pg_addr), .full(req_full), .empty(pg_empty));

   fragdma_fifo #(.W(ACK_W), .DEPTH(ACK_DEPTH)) u_ack (
      .clk(clk), .rst_n(rst_n), .push(ack_push), .din(ack_din),
      .pop(ack_pop), .dout(ack_data), .full(ack_full), .empty(ack_empty));

   assign lk_ready   = (st == ST_FILL);
   assign acc        = lk_valid && lk_ready;
   assign room       = (wcnt < WW'(PAGE_WORDS));
   assign store_beat = acc && room && (have_half || lk_end);
   assign beats_nx   = beats + BW'(store_beat);
   assign is_last    = ((rd_idx + 1'b1) == beats);
   assign pg_pop     = (st == ST_PAGE) && !pg_empty;
   assign ack_push   = (st == ST_ACK) && !ack_full;

   always_comb begin
      ack_din = '0;
      ack_din[ACK_W-1:32]   = page_base;
      ack_din[STAT_OVF_BIT] = ovf;
      ack_din[STAT_PAD_BIT] = pad;
      ack_din[LEN_W-1:0]    = LEN_W'({wcnt, 2'b00});
   end

   assign m_req   = (st == ST_REQ);
   assign m_valid = (st == ST_SEND);
   assign m_addr  = burst_addr;
   assign m_data  = bbuf[rd_idx[BIW-1:0]];
   assign m_last  = (st == ST_SEND) && is_last;

   always_ff @(posedge clk) begin
      if (store_beat)
         bbuf[beats[BIW-1:0]] <= have_half ? {lk_data, half_lo} : {32'd0, lk_data};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_PAGE;
         page_base  <= '0;
         burst_addr <= '0;
         wcnt       <= '0;
         beats      <= '0;
         rd_idx     <= '0;
         half_lo    <= '0;
         have_half  <= 1'b0;
         ovf        <= 1'b0;
         pad        <= 1'b0;
         done       <= 1'b0;
      end else begin
         unique case (st)
            ST_PAGE: if (!pg_empty) begin
               page_base  <= pg_addr;
               burst_addr <= pg_addr;
               st         <= ST_FILL;
            end
            ST_FILL: if (acc) begin
               if (room) begin
                  wcnt <= wcnt + 1'b1;
                  if (have_half)   have_half <= 1'b0;
                  else if (lk_end) pad <= 1'b1;
                  else begin
                     half_lo   <= lk_data;
                     have_half <= 1'b1;
                  end
               end else begin
                  ovf <= 1'b1;
               end
               beats <= beats_nx;
               if (lk_end) begin
                  done <= 1'b1;
                  st   <= (beats_nx != '0) ? ST_REQ : ST_ACK;
               end else if (beats_nx == BW'(BURST_BEATS)) begin
                  st <= ST_REQ;
               end
            end
            ST_REQ: if (m_gnt) begin
               rd_idx <= '0;
               st     <= ST_SEND;
            end
            ST_SEND: if (m_ready) begin
               rd_idx <= rd_idx + 1'b1;
               if (is_last) begin
                  burst_addr <= burst_addr + ADDR_W'({beats, 3'b000});
                  beats      <= '0;
                  st         <= done ? ST_ACK : ST_FILL;
               end
            end
            ST_ACK: if (!ack_full) begin
               wcnt      <= '0;
               have_half <= 1'b0;
               ovf       <= 1'b0;
               pad       <= 1'b0;
               done      <= 1'b0;
               st        <= ST_PAGE;
            end
            default: st <= ST_PAGE;
         endcase
      end
   end
endmodule

// File: rtl/frag_rx_dma.sv
module frag_rx_dma #(
   parameter int NUM_CH      = 4,
   parameter int ADDR_W      = 32,
   parameter int BURST_BYTES = 1024,
   parameter int PAGE_BYTES  = 4096,
   parameter int REQ_DEPTH   = 8,
   parameter int ACK_DEPTH   = 8,
   localparam int ACK_W      = ADDR_W + 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        req_push,
   input  logic [NUM_CH*ADDR_W-1:0] req_addr,
   output logic [NUM_CH-1:0]        req_full,
   input  logic [NUM_CH-1:0]        ack_pop,
   output logic [NUM_CH*ACK_W-1:0]  ack_data,
   output logic [NUM_CH-1:0]        ack_empty,
   input  logic [NUM_CH-1:0]        lk_valid,
   input  logic [NUM_CH*32-1:0]     lk_data,
   input  logic [NUM_CH-1:0]        lk_end,
   output logic [NUM_CH-1:0]        lk_ready,
   output logic                     m_valid,
   input  logic                     m_ready,
   output logic [ADDR_W-1:0]        m_addr,
   output logic [63:0]              m_data,
   output logic                     m_last,
   input  logic [NUM_CH-1:0]        irq_en,
   output logic                     irq
);
   localparam int BURST_BEATS = BURST_BYTES / 8;
   localparam int PAGE_WORDS  = PAGE_BYTES / 4;
   localparam int IW          = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   initial begin : p_param_chk
      assert (NUM_CH >= 1 && NUM_CH <= 4) else $fatal(1, "NUM_CH out of range");
      assert (BURST_BYTES >= 8 && BURST_BYTES <= 1024 && BURST_BYTES % 8 == 0)
         else $fatal(1, "BURST_BYTES must be a multiple of 8 up to 1024");
      assert (PAGE_BYTES % BURST_BYTES == 0) else $fatal(1, "PAGE_BYTES must be a multiple of BURST_BYTES");
      assert (PAGE_BYTES < (1 << 24)) else $fatal(1, "PAGE_BYTES exceeds length field");
      assert (REQ_DEPTH >= 1 && ACK_DEPTH >= 1) else $fatal(1, "queue depth must be positive");
   end

   logic [NUM_CH-1:0]        ch_req, ch_valid, ch_last, arb_gnt, ch_ready;
   logic [ADDR_W-1:0]        ch_addr [NUM_CH];
   logic [63:0]              ch_data [NUM_CH];
   logic [IW-1:0]            arb_owner;
   logic                     burst_done;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         assign ch_ready[i] = m_ready && arb_gnt[i];
         fragdma_chan #(
            .ADDR_W(ADDR_W), .BURST_BEATS(BURST_BEATS), .PAGE_WORDS(PAGE_WORDS),
            .REQ_DEPTH(REQ_DEPTH), .ACK_DEPTH(ACK_DEPTH)
         ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .req_push(req_push[i]), .req_addr(req_addr[i*ADDR_W +: ADDR_W]),
            .req_full(req_full[i]),
            .ack_pop(ack_pop[i]), .ack_data(ack_data[i*ACK_W +: ACK_W]),
            .ack_empty(ack_empty[i]),
            .lk_valid(lk_valid[i]), .lk_data(lk_data[i*32 +: 32]),
            .lk_end(lk_end[i]), .lk_ready(lk_ready[i]),
            .m_req(ch_req[i]), .m_gnt(arb_gnt[i]),
            .m_valid(ch_valid[i]), .m_ready(ch_ready[i]),
            .m_addr(ch_addr[i]), .m_data(ch_data[i]), .m_last(ch_last[i]));
      end
   endgenerate

   fragdma_rr_arb #(.N(NUM_CH)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(ch_req), .done(burst_done),
      .gnt(arb_gnt), .owner(arb_owner));

   assign m_valid    = |ch_valid;
   assign m_last     = |ch_last;
   assign m_addr     = ch_addr[arb_owner];
   assign m_data     = ch_data[arb_owner];
   assign burst_done = m_valid && m_ready && m_last;
   assign irq        = |(irq_en & ~ack_empty);
endmodule

// File: rtl/fragdma_chk.sv
module fragdma_chk #(
   parameter int NUM_CH      = 4,
   parameter int ADDR_W      = 32,
   parameter int BURST_BEATS = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_valid,
   input logic              m_ready,
   input logic [ADDR_W-1:0] m_addr,
   input logic [63:0]       m_data,
   input logic              m_last,
   input logic [NUM_CH-1:0] arb_gnt
);
   localparam int CW = $clog2(BURST_BEATS + 1);
   logic [CW-1:0] bcnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                           bcnt <= '0;
      else if (m_valid && m_ready && m_last) bcnt <= '0;
      else if (m_valid && m_ready)          bcnt <= bcnt + 1'b1;
   end

   // R8
   single_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(arb_gnt));

   // R8
   valid_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (arb_gnt != '0));

   // R10
   hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data) && $stable(m_last)));

   // R4
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_ready) |-> (bcnt < CW'(BURST_BEATS)));

   // R4
   burst_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_ready && !m_last) |=> (m_valid && $stable(m_addr)));

   // R1
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (m_addr[2:0] == 3'b000));
endmodule

bind frag_rx_dma fragdma_chk #(
   .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BURST_BEATS(BURST_BYTES / 8)
) u_chk (
   .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
   .m_addr(m_addr), .m_data(m_data), .m_last(m_last), .arb_gnt(arb_gnt));

// File: tb/frag_rx_dma_tb_top.sv
module frag_rx_dma_tb_top;
   localparam int N    = 2;
   localparam int AW   = 32;
   localparam int BB   = 32;
   localparam int PB   = 64;
   localparam int ACKW = AW + 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      req_push = '0;
   logic [N*AW-1:0]   req_addr = '0;
   logic [N-1:0]      req_full;
   logic [N-1:0]      ack_pop = '0;
   logic [N*ACKW-1:0] ack_data;
   logic [N-1:0]      ack_empty;
   logic [N-1:0]      lk_valid = '0;
   logic [N*32-1:0]   lk_data = '0;
   logic [N-1:0]      lk_end = '0;
   logic [N-1:0]      lk_ready;
   logic              m_valid;
   logic              m_ready = 1'b1;
   logic [AW-1:0]     m_addr;
   logic [63:0]       m_data;
   logic              m_last;
   logic [N-1:0]      irq_en = '0;
   logic              irq;

   int n_total = 0;
   int n_bad   = 0;
   int rdy_div = 1;
   int cyc     = 0;

   frag_rx_dma #(
      .NUM_CH(N), .ADDR_W(AW), .BURST_BYTES(BB), .PAGE_BYTES(PB),
      .REQ_DEPTH(4), .ACK_DEPTH(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_push(req_push), .req_addr(req_addr),
      .req_full(req_full), .ack_pop(ack_pop), .ack_data(ack_data),
      .ack_empty(ack_empty), .lk_valid(lk_valid), .lk_data(lk_data),
      .lk_end(lk_end), .lk_ready(lk_ready), .m_valid(m_valid),
      .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data), .m_last(m_last),
      .irq_en(irq_en), .irq(irq));

   always #5 clk = ~clk;

   // memory model and burst log fed from the master port
   logic [63:0] memw [int];
   int  bidx = 0;
   int  nb = 0;
   int  b_addr [64];
   int  b_len  [64];
   int  unstable = 0;
   logic          pv = 1'b0, pr = 1'b0, pl = 1'b0;
   logic [AW-1:0] pa = '0;
   logic [63:0]   pd = '0;

   initial forever begin
      @(negedge clk);
      cyc++;
      m_ready = ((cyc % rdy_div) == 0);
   end

   initial forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
         if (pv && !pr && !(m_valid && m_addr == pa && m_data == pd && m_last == pl))
            unstable++;
         if (m_valid && m_ready) begin
            memw[int'(m_addr >> 3) + bidx] = m_data;
            bidx++;
            if (m_last) begin
               if (nb < 64) begin
                  b_addr[nb] = int'(m_addr);
                  b_len[nb]  = bidx;
               end
               nb++;
               bidx = 0;
            end
         end
      end
      pv = m_valid; pr = m_ready; pa = m_addr; pd = m_data; pl = m_last;
   end

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] rdmem(input int a);
      if (memw.exists(a >> 3)) return memw[a >> 3];
      return 64'hDEAD_BEEF_DEAD_BEEF;
   endfunction

   task automatic push_page(input int ch, input logic [AW-1:0] a);
      @(negedge clk);
      req_push[ch] = 1'b1;
      req_addr[ch*AW +: AW] = a;
      @(negedge clk);
      req_push[ch] = 1'b0;
   endtask

   task automatic send_frag(input int ch, input int nw, input logic [31:0] base);
      for (int k = 0; k < nw; k++) begin
         @(negedge clk);
         lk_valid[ch] = 1'b1;
         lk_data[ch*32 +: 32] = base + k;
         lk_end[ch] = (k == nw - 1);
         while (!lk_ready[ch]) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      lk_valid[ch] = 1'b0;
      lk_end[ch]   = 1'b0;
   endtask

   task automatic pop_ack(input int ch, output logic [ACKW-1:0] e);
      @(negedge clk);
      while (ack_empty[ch]) @(negedge clk);
      e = ack_data[ch*ACKW +: ACKW];
      ack_pop[ch] = 1'b1;
      @(negedge clk);
      ack_pop[ch] = 1'b0;
   endtask

   task automatic check_data(input string req, input int a, input int nw, input logic [31:0] base);
      for (int k = 0; k < nw; k += 2) begin
         logic [31:0] hi;
         hi = (k + 1 < nw) ? base + k + 1 : 32'd0;
         check(req, "beat", rdmem(a + k * 4), {hi, base + k});
      end
   endtask

   task automatic t_reset();
      check("R11", "lk_ready", 64'(lk_ready), 64'(0));
      check("R11", "m_valid", 64'(m_valid), 64'(0));
      check("R11", "ack_empty", 64'(ack_empty), 64'(2'b11));
      check("R11", "irq", 64'(irq), 64'(0));
   endtask

   task automatic t_even_irq();
      logic [ACKW-1:0] e;
      push_page(0, 32'h1000);
      send_frag(0, 6, 32'hA000_0000);
      while (ack_empty[0]) @(negedge clk);
      #1;
      check("R9", "irq disabled", 64'(irq), 64'(0));
      irq_en = 2'b10;
      #1;
      check("R9", "irq other channel", 64'(irq), 64'(0));
      irq_en = 2'b01;
      #1;
      check("R9", "irq enabled", 64'(irq), 64'(1));
      pop_ack(0, e);
      #1;
      check("R9", "irq after pop", 64'(irq), 64'(0));
      irq_en = 2'b00;
      check("R1", "page addr", 64'(e[ACKW-1:32]), 64'(32'h1000));
      check("R1", "len", 64'(e[23:0]), 64'(24));
      check("R1", "status", 64'(e[25:24]), 64'(0));
      check_data("R2", 32'h1000, 6, 32'hA000_0000);
   endtask

   task automatic t_odd();
      logic [ACKW-1:0] e;
      push_page(1, 32'h2000);
      send_frag(1, 5, 32'hB000_0000);
      pop_ack(1, e);
      check("R3", "len", 64'(e[23:0]), 64'(20));
      check("R3", "pad bit", 64'(e[25:24]), 64'(2'b10));
      check("R1", "page addr", 64'(e[ACKW-1:32]), 64'(32'h2000));
      check_data("R3", 32'h2000, 5, 32'hB000_0000);
   endtask

   task automatic t_split();
      logic [ACKW-1:0] e;
      int nb0;
      nb0 = nb;
      push_page(0, 32'h3000);
      send_frag(0, 12, 32'hC000_0000);
      pop_ack(0, e);
      check("R4", "burst count", 64'(nb - nb0), 64'(2));
      check("R4", "burst0 addr", 64'(b_addr[nb0]), 64'(32'h3000));
      check("R4", "burst0 len", 64'(b_len[nb0]), 64'(4));
      check("R4", "burst1 addr", 64'(b_addr[nb0 + 1]), 64'(32'h3020));
      check("R4", "burst1 len", 64'(b_len[nb0 + 1]), 64'(2));
      check("R4", "len", 64'(e[23:0]), 64'(48));
      check_data("R4", 32'h3000, 12, 32'hC000_0000);
   endtask

   task automatic t_no_page();
      logic [ACKW-1:0] e;
      fork
         send_frag(0, 4, 32'hD000_0000);
         begin
            repeat (8) @(negedge clk);
            #1;
            check("R5", "ready without page", 64'(lk_ready[0]), 64'(0));
            push_page(0, 32'h4000);
         end
      join
      pop_ack(0, e);
      check("R5", "len", 64'(e[23:0]), 64'(16));
      check_data("R5", 32'h4000, 4, 32'hD000_0000);
   endtask

   task automatic t_truncate();
      logic [ACKW-1:0] e;
      push_page(1, 32'h5000);
      send_frag(1, 20, 32'hE000_0000);
      pop_ack(1, e);
      check("R6", "len", 64'(e[23:0]), 64'(PB));
      check("R6", "status", 64'(e[25:24]), 64'(2'b01));
      check_data("R6", 32'h5000, 16, 32'hE000_0000);
      check("R6", "beyond page", 64'(memw.exists(32'h5040 >> 3)), 64'(0));
   endtask

   task automatic t_ack_full();
      logic [ACKW-1:0] e;
      push_page(0, 32'h8000);
      push_page(0, 32'h8100);
      push_page(0, 32'h8200);
      send_frag(0, 2, 32'h1100_0000);
      send_frag(0, 2, 32'h1200_0000);
      send_frag(0, 2, 32'h1300_0000);
      push_page(0, 32'h8300);
      @(negedge clk);
      lk_valid[0] = 1'b1;
      lk_data[31:0] = 32'h1400_0000;
      lk_end[0] = 1'b0;
      repeat (10) @(negedge clk);
      #1;
      check("R7", "ready while ack full", 64'(lk_ready[0]), 64'(0));
      lk_valid[0] = 1'b0;
      pop_ack(0, e);
      check("R7", "entry1", 64'(e[ACKW-1:32]), 64'(32'h8000));
      send_frag(0, 2, 32'h1400_0000);
      pop_ack(0, e);
      check("R7", "entry2", 64'(e[ACKW-1:32]), 64'(32'h8100));
      pop_ack(0, e);
      check("R7", "entry3", 64'(e[ACKW-1:32]), 64'(32'h8200));
      pop_ack(0, e);
      check("R7", "entry4", 64'(e[ACKW-1:32]), 64'(32'h8300));
      check("R7", "entry4 len", 64'(e[23:0]), 64'(8));
      check_data("R7", 32'h8200, 2, 32'h1300_0000);
      check_data("R7", 32'h8300, 2, 32'h1400_0000);
   endtask

   task automatic t_rotate();
      logic [ACKW-1:0] e0, e1;
      int nb0;
      rdy_div = 3;
      push_page(0, 32'h6000);
      push_page(1, 32'h7000);
      nb0 = nb;
      fork
         send_frag(0, 16, 32'h2100_0000);
         send_frag(1, 16, 32'h2200_0000);
      join
      pop_ack(0, e0);
      pop_ack(1, e1);
      rdy_div = 1;
      check("R8", "burst count", 64'(nb - nb0), 64'(4));
      for (int j = 0; j < 3; j++)
         check("R8", "alternation", 64'((b_addr[nb0 + j] >= 32'h7000) != (b_addr[nb0 + j + 1] >= 32'h7000)), 64'(1));
      check("R8", "ch0 len", 64'(e0[23:0]), 64'(64));
      check("R8", "ch1 len", 64'(e1[23:0]), 64'(64));
      check_data("R8", 32'h6000, 16, 32'h2100_0000);
      check_data("R8", 32'h7000, 16, 32'h2200_0000);
      check("R10", "stalled payload stable", 64'(unstable), 64'(0));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_even_irq();
      t_odd();
      t_split();
      t_no_page();
      t_truncate();
      t_ack_full();
      t_rotate();
      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end
endmodule